// File: doc/BRIEF.md
# Segment Polarity Mask Unpacker

This block turns a variable-length polarity command, delivered one byte at a time, into a register with one reversal bit per track segment. The opening byte is recognised by a fixed header in its top five bits and carries three reversal bits in its low three bits. Every byte after it carries seven more reversal bits below its top bit. The top bit of a later byte is a continuation marker and is not used here, because the end of a command is signalled by a separate last strobe. Bits are taken most significant first and assigned to ascending segment numbers. Bits that fall past the configured segment count are dropped.

The reversal bits collect in a staging copy. The visible mask changes in one step when the final byte arrives, and a one-cycle completion strobe marks that step. A power-on clear returns every segment to the unreversed state and abandons any command that is only partly received. The controller has three states. `IDLE` waits for the first byte of a command. `GATHER` collects the bits of a command whose header was accepted. `DISCARD` swallows the remaining bytes of a command whose header was rejected. The transitions are:
- header-accept: `IDLE` to `GATHER`
- header-reject: `IDLE` to `DISCARD`
- lone-byte drop: `IDLE` to `IDLE`
- body-byte: `GATHER` to `GATHER`
- commit: `GATHER` to `IDLE`
- drain: `DISCARD` to `DISCARD`
- drain-end: `DISCARD` to `IDLE`
- clear-abort: any state to `IDLE`

Top module: `polmask_unpacker`

## Requirements
- R1: After reset, and on the clock edge where `pwr_clr` is high, `seg_mask` becomes all zeros, meaning every segment is unreversed.
- R2: A command whose first byte does not have bits 7..3 equal to 10010 is discarded up to and including its last byte. It changes nothing and produces no `upd_done`.
- R3: In the first byte, bit 2 sets segment 1, bit 1 sets segment 2 and bit 0 sets segment 3. Segment k is `seg_mask` bit k-1.
- R4: The n-th following byte (n starting at 1) assigns its bits 6 down to 0 to segments 4+7(n-1) upward, in that order. Bit 7 of a following byte is ignored.
- R5: Reversal bits whose segment number is above NSEG are dropped and have no effect on any output.
- R6: `seg_mask` keeps its value while a command is partly received. It takes the new value only on the edge that accepts the last byte, and the new value is visible from the next cycle.
- R7: `upd_done` is high for exactly one cycle, in the cycle after the last byte of an accepted command, which is the same cycle in which the new mask first appears.
- R8: A command made of one byte (valid and last together on its first byte) is dropped without any update and without `upd_done`.
- R9: Segments that a short command does not reach keep their previous values when that command commits.
- R10: `pwr_clr` abandons a partly received command. If it coincides with a last byte, the clear wins: the mask becomes zero and no `upd_done` follows.
- R11: Cycles with `in_valid` low are ignored, so gaps between the bytes of a command do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_clr | input | 1 | Power-on clear: all segments unreversed, command abandoned |
| in_valid | input | 1 | `in_byte` and `in_last` are valid this cycle |
| in_byte | input | 8 | Command byte |
| in_last | input | 1 | This byte ends the command |
| seg_mask | output | NSEG | Reversal mask, bit k-1 is segment k |
| upd_done | output | 1 | One-cycle pulse: mask update complete |

## Verification
The power-on clear and the commit of a final byte can fall on the same clock edge. The bench provokes this by raising `pwr_clr` while it presents a last byte that would otherwise have completed a valid command. In the following cycle it expects a zero mask and no completion pulse. The bench also compares the design against a behavioural model on every cycle, and that model gives the clear priority in the same way.

// File: rtl/polmask_pkg.sv
package polmask_pkg;

    typedef enum logic [1:0] {
        PM_IDLE    = 2'd0,
        PM_GATHER  = 2'd1,
        PM_DISCARD = 2'd2
    } pm_state_e;

    // Opening byte: bits 7..3 must match this pattern
    localparam logic [4:0] PM_HDR = 5'b10010;
    // Reversal bits in the opening byte and in each later byte
    localparam int PM_HEAD_BITS = 3;
    localparam int PM_BODY_BITS = 7;

endpackage

// File: rtl/polmask_ctrl.sv
module polmask_ctrl
    import polmask_pkg::*;
#(
    parameter int NSEG = 14,
    parameter int PW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic [4:0]    hdr_bits,
    output logic          load_head,
    output logic          load_body,
    output logic          commit,
    output logic [PW-1:0] pos
);

    pm_state_e state_q, state_nx;
    logic      hdr_ok;

    assign hdr_ok = (hdr_bits == PM_HDR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            PM_IDLE: begin
                if (in_valid && !in_last)
                    state_nx = hdr_ok ? PM_GATHER : PM_DISCARD;
            end
            PM_GATHER: begin
                if (in_valid && in_last) state_nx = PM_IDLE;
            end
            PM_DISCARD: begin
                if (in_valid && in_last) state_nx = PM_IDLE;
            end
            default: state_nx = PM_IDLE;
        endcase
        if (clr) state_nx = PM_IDLE;
    end

    // outputs
    always_comb begin
        load_head = 1'b0;
        load_body = 1'b0;
        unique case (state_q)
            PM_IDLE:    load_head = in_valid && !in_last && hdr_ok && !clr;
            PM_GATHER:  load_body = in_valid && !clr;
            PM_DISCARD: ;
            default:    ;
        endcase
        commit = load_body && in_last;
    end

    // stream index of the most significant reversal bit in the next byte
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pos <= '0;
        else if (load_head)
            pos <= PW'(PM_HEAD_BITS);
        else if (load_body && (pos < PW'(NSEG)))
            pos <= pos + PW'(PM_BODY_BITS);
    end

endmodule

// File: rtl/polmask_slot.sv
module polmask_slot
    import polmask_pkg::*;
#(
    parameter int SEG_IDX = 0,
    parameter int PW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load_head,
    input  logic          load_body,
    input  logic [PW-1:0] pos,
    input  logic          head_val,
    input  logic [6:0]    body_bits,
    output logic          bit_nx
);

    localparam logic [PW:0] SEG_W = (PW+1)'(SEG_IDX);

    logic        stage_q;
    logic [PW:0] diff;
    logic [2:0]  off;
    logic        hit;

    always_comb begin
        diff   = SEG_W - {1'b0, pos};
        off    = diff[2:0];
        hit    = load_body && ({1'b0, pos} <= SEG_W)
                 && (diff < (PW+1)'(PM_BODY_BITS));
        bit_nx = stage_q;
        if (load_head)
            bit_nx = head_val;
        else if (hit)
            bit_nx = body_bits[3'd6 - off];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) stage_q <= 1'b0;
        else               stage_q <= bit_nx;
    end

endmodule

// File: rtl/polmask_unpacker.sv
module polmask_unpacker
    import polmask_pkg::*;
#(
    parameter int NSEG = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_clr,
    input  logic            in_valid,
    input  logic [7:0]      in_byte,
    input  logic            in_last,
    output logic [NSEG-1:0] seg_mask,
    output logic            upd_done
);

    localparam int PW = $clog2(NSEG + PM_BODY_BITS + 1);

    logic            load_head, load_body, commit;
    logic [PW-1:0]   pos;
    logic [NSEG-1:0] head_val;
    logic [NSEG-1:0] stage_nx;

    polmask_ctrl #(.NSEG(NSEG), .PW(PW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pwr_clr),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .hdr_bits  (in_byte[7:3]),
        .load_head (load_head),
        .load_body (load_body),
        .commit    (commit),
        .pos       (pos)
    );

    for (genvar j = 0; j < NSEG; j++) begin : g_seg
        if (j < PM_HEAD_BITS) begin : g_head
            assign head_val[j] = in_byte[PM_HEAD_BITS-1-j];
        end else begin : g_keep
            assign head_val[j] = seg_mask[j];
        end

        polmask_slot #(.SEG_IDX(j), .PW(PW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (pwr_clr),
            .load_head (load_head),
            .load_body (load_body),
            .pos       (pos),
            .head_val  (head_val[j]),
            .body_bits (in_byte[6:0]),
            .bit_nx    (stage_nx[j])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n || pwr_clr) seg_mask <= '0;
        else if (commit)       seg_mask <= stage_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) upd_done <= 1'b0;
        else        upd_done <= commit;
    end

endmodule

// File: rtl/polmask_chk.sv
module polmask_chk #(
    parameter int NSEG = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwr_clr,
    input logic            in_valid,
    input logic            in_last,
    input logic [NSEG-1:0] seg_mask,
    input logic            upd_done
);

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_done && !$past(pwr_clr)) |-> $stable(seg_mask));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> $past(in_valid && in_last && !pwr_clr));

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_clr |=> (seg_mask == '0));

    // R10
    clear_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_clr |=> !upd_done);

endmodule

bind polmask_unpacker polmask_chk #(.NSEG(NSEG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_clr  (pwr_clr),
    .in_valid (in_valid),
    .in_last  (in_last),
    .seg_mask (seg_mask),
    .upd_done (upd_done)
);

// File: tb/sim_polmask_unpacker.sv
`timescale 1ns/1ps
module sim_polmask_unpacker;

    localparam int NSEG = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwr_clr = 1'b0;
    logic            in_valid = 1'b0;
    logic [7:0]      in_byte = 8'h00;
    logic            in_last = 1'b0;
    logic [NSEG-1:0] seg_mask;
    logic            upd_done;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    polmask_unpacker #(.NSEG(NSEG)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_clr  (pwr_clr),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_last  (in_last),
        .seg_mask (seg_mask),
        .upd_done (upd_done)
    );

    // behavioural reference model
    logic [NSEG-1:0] m_mask = '0;
    logic            m_done = 1'b0;
    logic [7:0]      m_q[$];

    always @(posedge clk) begin
        if (!rst_n || pwr_clr) begin
            m_mask = '0;
            m_done = 1'b0;
            m_q.delete();
        end else begin
            m_done = 1'b0;
            if (in_valid) begin
                m_q.push_back(in_byte);
                if (in_last) begin
                    if (m_q.size() >= 2 && m_q[0][7:3] == 5'b10010) begin
                        logic [NSEG-1:0] nm;
                        int sidx;
                        nm = m_mask;
                        sidx = 0;
                        for (int k = 0; k < m_q.size(); k++) begin
                            int nb;
                            nb = (k == 0) ? 3 : 7;
                            for (int t = 0; t < nb; t++) begin
                                if (sidx < NSEG) nm[sidx] = m_q[k][nb-1-t];
                                sidx++;
                            end
                        end
                        m_mask = nm;
                        m_done = 1'b1;
                    end
                    m_q.delete();
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 mask vs model", 32'(seg_mask), 32'(m_mask));
            chk("R7 done vs model", 32'(upd_done), 32'(m_done));
        end
    end

    task automatic put(input logic [7:0] b, input logic l);
        in_valid = 1'b1;
        in_byte  = b;
        in_last  = l;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset mask", 32'(seg_mask), 32'h0);
        chk("R1 reset done", 32'(upd_done), 32'h0);

        // worked example: segments 7 and 11..14
        put(8'h90, 0); put(8'h88, 0); put(8'h7A, 1);
        chk("R4 R5 example mask", 32'(seg_mask), 32'h3C40);
        chk("R7 example done", 32'(upd_done), 32'h1);
        @(negedge clk);
        chk("R7 done one cycle", 32'(upd_done), 32'h0);

        // short command: first-byte bits plus one body byte
        put(8'h97, 0); put(8'h80, 1);
        chk("R3 R9 short command", 32'(seg_mask), 32'h3C07);

        // partial command with gaps and bit 7 set
        put(8'h90, 0); put(8'hFF, 0);
        chk("R6 partial holds mask", 32'(seg_mask), 32'h3C07);
        chk("R6 partial no done", 32'(upd_done), 32'h0);
        idle(3);
        chk("R11 gap holds mask", 32'(seg_mask), 32'h3C07);
        put(8'hFF, 1);
        chk("R4 R11 after gap", 32'(seg_mask), 32'h3FF8);

        // wrong header
        put(8'hA5, 0); put(8'h7F, 1);
        chk("R2 bad header mask", 32'(seg_mask), 32'h3FF8);
        chk("R2 bad header done", 32'(upd_done), 32'h0);

        // single-byte command
        put(8'h97, 1);
        chk("R8 lone byte mask", 32'(seg_mask), 32'h3FF8);
        chk("R8 lone byte done", 32'(upd_done), 32'h0);

        // clear in the middle of a command
        put(8'h97, 0); put(8'hFF, 0);
        pwr_clr = 1'b1;
        @(negedge clk);
        pwr_clr = 1'b0;
        chk("R10 clear mid command", 32'(seg_mask), 32'h0);
        put(8'h7F, 1);
        chk("R10 aborted tail mask", 32'(seg_mask), 32'h0);
        chk("R10 aborted tail done", 32'(upd_done), 32'h0);

        // clear on the same edge as a last byte
        put(8'h97, 0); put(8'h80, 1);
        chk("R3 set before clash", 32'(seg_mask), 32'h0007);
        put(8'h90, 0); put(8'hFF, 0);
        pwr_clr = 1'b1;
        put(8'h7F, 1);
        pwr_clr = 1'b0;
        chk("R10 clash mask", 32'(seg_mask), 32'h0);
        chk("R10 clash done", 32'(upd_done), 32'h0);

        // back-to-back commands
        put(8'h92, 0); put(8'h80, 1);
        chk("R3 first of pair", 32'(seg_mask), 32'h0002);
        chk("R7 first of pair done", 32'(upd_done), 32'h1);
        put(8'h91, 0); put(8'h81, 1);
        chk("R4 second of pair", 32'(seg_mask), 32'h0204);
        chk("R7 second of pair done", 32'(upd_done), 32'h1);

        // overlong command: surplus bits dropped
        put(8'h97, 0); put(8'hFF, 0); put(8'hFF, 0); put(8'h80, 0); put(8'h80, 1);
        chk("R5 surplus dropped", 32'(seg_mask), 32'h3FFF);

        idle(3);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule